// File: doc/BRIEF.md
# Orbit-Aligned Trigger Test Pattern Generator

This block makes artificial trigger activity on the 16 detector trigger lines so that the downstream decoding path can be commissioned without beam. A pattern memory holds one 16-bit word for every bunch-crossing slot of an orbit (3564 slots by default). Each bit of a word drives one trigger line. Once the generator is enabled it waits for the next orbit pulse. It then plays one memory word per clock, starting at slot 0. Every later orbit pulse brings playback back to slot 0.

Two run modes exist, and both are latched when playback starts. In counted mode, playback lasts a programmed number of clocks, then stops and raises a done flag. In free-running mode, playback goes on for as long as the enable stays high. An output multiplexer passes the real trigger lines through while the generator is disabled. While it is enabled, the multiplexer substitutes the generated word, which is all zeros whenever no playback is in progress.

Top module: `tpg_top`

## Requirements
- R1: After reset, `active_o` and `done_o` are 0.
- R2: While `enable_i` is 0, `line_o` equals `line_i` in the same cycle.
- R3: While `enable_i` is 1 and no playback is in progress, `line_o` is all zeros whatever `line_i` carries.
- R4: An orbit pulse sampled at a clock edge while enabled, idle and not done starts playback. In the cycle after that edge, `line_o` carries the word at slot 0, and each further clock advances by one slot.
- R5: After slot SLOTS-1, playback continues at slot 0 without needing an orbit pulse.
- R6: An orbit pulse sampled during playback makes the next cycle show slot 0.
- R7: In counted mode (`counted_i`=1 at start) with count N>0, exactly N words are played. After that, `line_o` is zero, `active_o` is 0 and `done_o` is 1.
- R8: In counted mode with a count of 0, the starting orbit plays no word and sets `done_o` directly.
- R9: While `done_o` is 1, later orbit pulses do not restart playback. Dropping `enable_i` and raising it again re-arms the generator.
- R10: A clock edge with `enable_i` at 0 clears `active_o` and `done_o`. `line_o` switches to `line_i` in the same cycle that enable falls.
- R11: `counted_i` and `cycles_i` are captured at the start edge, so changing them during playback has no effect on its length.
- R12: A write with `wr_en_i` at 1 stores `wr_data_i` at slot `wr_addr_i`. Addresses of SLOTS or above are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_i | input | 1 | One-cycle orbit marker |
| enable_i | input | 1 | Generator enable and output select |
| counted_i | input | 1 | 1 = counted mode, 0 = free running |
| cycles_i | input | 32 | Playback length for counted mode |
| wr_en_i | input | 1 | Pattern memory write strobe |
| wr_addr_i | input | 12 | Slot written |
| wr_data_i | input | 16 | Pattern word written |
| line_i | input | 16 | Real trigger lines |
| line_o | output | 16 | Lines handed to the decoder |
| active_o | output | 1 | Playback in progress |
| done_o | output | 1 | Counted playback finished |

## Verification
The properties assume the orbit marker lasts one cycle and that the mode and count inputs only matter at the start edge. They do not assume the marker arrives every SLOTS cycles, so both wrap-around and early re-alignment are legal inputs. The stimulus changes every input on the falling clock edge only. It pulses the orbit for exactly one cycle, and it deliberately moves the mode and count inputs in the middle of counted playback to exercise the capture rule.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  // Slot that follows cur in an orbit whose final slot index is last.
  function automatic int unsigned slot_after(int unsigned cur, int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  // Counted playback ends after the clock in which one word remains.
  function automatic logic final_word(logic counted, logic [31:0] remain);
    return counted && (remain == 32'd1);
  endfunction
endpackage

// File: rtl/tpg_mem.sv
module tpg_mem #(
  parameter int LANES = 16,
  parameter int SLOTS = 3564,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [LANES-1:0] rd_data
);
  logic [LANES-1:0] store [SLOTS];
  logic             in_range;

  assign in_range = 32'(wr_addr) < SLOTS;

  always_ff @(posedge clk) begin
    if (wr_en && in_range) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int SLOTS = 3564,
  parameter int CNT_W = 32,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit,
  input  logic             enable,
  input  logic             counted_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             active,
  output logic             done,
  output logic             counted,
  output logic [AW-1:0]    slot,
  output logic [CNT_W-1:0] remain
);
  localparam int unsigned LAST = SLOTS - 1;

  logic          start_ev;
  logic          empty_ev;
  logic          stop_ev;
  logic [AW-1:0] slot_nxt;

  assign start_ev = enable && orbit && !active && !done;
  assign empty_ev = start_ev && counted_i && (cycles_i == '0);
  assign stop_ev  = active && final_word(counted, 32'(remain));
  assign slot_nxt = orbit ? '0 : AW'(slot_after(32'(slot), LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done    <= 1'b0;
      counted <= 1'b0;
      slot    <= '0;
      remain  <= '0;
    end else if (!enable) begin
      active <= 1'b0;
      done   <= 1'b0;
      slot   <= '0;
    end else if (start_ev) begin
      counted <= counted_i;
      remain  <= cycles_i;
      slot    <= '0;
      if (empty_ev) done   <= 1'b1;
      else          active <= 1'b1;
    end else if (active) begin
      slot <= slot_nxt;
      if (counted) remain <= remain - CNT_W'(1);
      if (stop_ev) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpg_mux.sv
module tpg_mux #(
  parameter int LANES = 16
) (
  input  logic             enable,
  input  logic             active,
  input  logic [LANES-1:0] word,
  input  logic [LANES-1:0] line_i,
  output logic [LANES-1:0] line_o
);
  logic [LANES-1:0] gen;

  assign gen    = active ? word : '0;
  assign line_o = enable ? gen : line_i;
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int LANES = 16,
  parameter int SLOTS = 3564,
  parameter int CNT_W = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_i,
  input  logic             enable_i,
  input  logic             counted_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [LANES-1:0] wr_data_i,
  input  logic [LANES-1:0] line_i,
  output logic [LANES-1:0] line_o,
  output logic             active_o,
  output logic             done_o
);
  logic [AW-1:0]    slot_w;
  logic [CNT_W-1:0] remain_w;
  logic             counted_w;
  logic [LANES-1:0] word_w;

  tpg_mem #(.LANES(LANES), .SLOTS(SLOTS), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(slot_w), .rd_data(word_w)
  );

  tpg_seq #(.SLOTS(SLOTS), .CNT_W(CNT_W), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .orbit(orbit_i), .enable(enable_i),
    .counted_i(counted_i), .cycles_i(cycles_i),
    .active(active_o), .done(done_o), .counted(counted_w),
    .slot(slot_w), .remain(remain_w)
  );

  tpg_mux #(.LANES(LANES)) u_mux (
    .enable(enable_i), .active(active_o), .word(word_w),
    .line_i(line_i), .line_o(line_o)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int LANES = 16,
  parameter int SLOTS = 3564,
  parameter int CNT_W = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             orbit,
  input logic             enable,
  input logic [LANES-1:0] line_i,
  input logic [LANES-1:0] line_o,
  input logic             active,
  input logic             done,
  input logic             counted,
  input logic [AW-1:0]    slot,
  input logic [CNT_W-1:0] remain
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> line_o == line_i); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !active |-> line_o == '0); // R3
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    enable && orbit && !active && !done |=> active || done); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && active && !orbit && slot != LAST |=> !active || slot == $past(slot) + AW'(1)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && active && !orbit && slot == LAST |=> !active || slot == '0); // R5
  AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    enable && active && orbit |=> !active || slot == '0); // R6
  AST_COUNT_END: assert property (@(posedge clk) disable iff (!rst_n)
    enable && active && counted && remain == CNT_W'(1) |=> !active && done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !active && !done); // R10
endmodule

bind tpg_top tpg_checker #(.LANES(LANES), .SLOTS(SLOTS), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .orbit(orbit_i), .enable(enable_i),
  .line_i(line_i), .line_o(line_o), .active(active_o), .done(done_o),
  .counted(counted_w), .slot(slot_w), .remain(remain_w)
);

// File: tb/tpg_top_bench.sv
module tpg_top_bench;
  localparam int LANES = 16;
  localparam int SLOTS = 3564;
  localparam int CNT_W = 32;
  localparam int AW    = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             orbit_i = 1'b0;
  logic             enable_i = 1'b0;
  logic             counted_i = 1'b0;
  logic [CNT_W-1:0] cycles_i = '0;
  logic             wr_en_i = 1'b0;
  logic [AW-1:0]    wr_addr_i = '0;
  logic [LANES-1:0] wr_data_i = '0;
  logic [LANES-1:0] line_i = '0;
  logic [LANES-1:0] line_o;
  logic             active_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tpg_top #(.LANES(LANES), .SLOTS(SLOTS), .CNT_W(CNT_W), .AW(AW)) u_tpg_top (
    .clk(clk), .rst_n(rst_n), .orbit_i(orbit_i), .enable_i(enable_i),
    .counted_i(counted_i), .cycles_i(cycles_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .line_i(line_i),
    .line_o(line_o), .active_o(active_o), .done_o(done_o)
  );

  // Bench's own pattern rule: a multiplicative hash of the slot number.
  function automatic logic [15:0] pat(int s);
    logic [31:0] h;
    h = 32'(s) * 32'd40503;
    return h[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive on a falling edge, then look at the outputs 1 ns later.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable_i = 1'b0; line_i = 16'hA5A5;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 active", 32'(active_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R2 reset bypass", 32'(line_o), 32'hA5A5);
  endtask

  task automatic t_load();
    for (int s = 0; s < SLOTS; s++) begin
      tick();
      wr_en_i = 1'b1; wr_addr_i = AW'(s); wr_data_i = pat(s);
    end
    tick();
    wr_addr_i = AW'(SLOTS + 5); wr_data_i = 16'hFFFF;  // out of range, dropped (R12)
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic t_bypass();
    for (int i = 0; i < 4; i++) begin
      tick();
      line_i = 16'(16'h1357 * (i + 3));
      #1 chk("R2 bypass", 32'(line_o), 32'(16'(16'h1357 * (i + 3))));
    end
  endtask

  task automatic t_idle();
    tick();
    enable_i = 1'b1; counted_i = 1'b0; line_i = 16'hFFFF;
    for (int i = 0; i < 5; i++) begin
      tick();
      line_i = 16'(16'h0F0F << i);
      #1 chk("R3 idle zero", 32'(line_o), 0);
      chk("R3 idle inactive", 32'(active_o), 0);
    end
  endtask

  task automatic t_free();
    tick(); orbit_i = 1'b1;
    for (int k = 0; k < SLOTS + 6; k++) begin
      tick(); orbit_i = 1'b0;
      #1 chk((k < SLOTS) ? "R4 free play" : "R5 wrap", 32'(line_o), 32'(pat(k % SLOTS)));
    end
    tick(); orbit_i = 1'b1;
    #1 chk("R6 before realign", 32'(line_o), 32'(pat(6)));
    tick(); orbit_i = 1'b0;
    #1 chk("R6 realign slot0", 32'(line_o), 32'(pat(0)));
    tick();
    #1 chk("R6 realign slot1", 32'(line_o), 32'(pat(1)));
    tick(); enable_i = 1'b0; line_i = 16'h1234;
    #1 chk("R10 immediate bypass", 32'(line_o), 32'h1234);
    tick();
    #1 chk("R10 active cleared", 32'(active_o), 0);
    tick(); enable_i = 1'b1;
    #1 chk("R3 rearmed quiet", 32'(line_o), 0);
  endtask

  task automatic t_counted();
    tick(); counted_i = 1'b1; cycles_i = 32'd5; orbit_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(); orbit_i = 1'b0;
      if (k == 0) cycles_i = 32'd100;  // R11: late change ignored
      if (k == 2) counted_i = 1'b0;    // R11: late mode change ignored
      #1 chk("R7 counted word", 32'(line_o), 32'(pat(k)));
    end
    tick();
    #1 chk("R7 silent after count", 32'(line_o), 0);
    chk("R11 length held", 32'(active_o), 0);
    chk("R7 done", 32'(done_o), 1);
    tick(); orbit_i = 1'b1;
    tick(); orbit_i = 1'b0;
    #1 chk("R9 no restart", 32'(active_o), 0);
    chk("R9 still quiet", 32'(line_o), 0);
    tick(); enable_i = 1'b0;
    tick();
    #1 chk("R10 done cleared", 32'(done_o), 0);
    tick(); enable_i = 1'b1; counted_i = 1'b1; cycles_i = 32'd3; orbit_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); orbit_i = 1'b0;
      #1 chk("R9 rearmed play", 32'(line_o), 32'(pat(k)));
    end
    tick();
    #1 chk("R7 second stop", 32'(done_o), 1);
  endtask

  task automatic t_zero();
    tick(); enable_i = 1'b0;
    tick(); enable_i = 1'b1; counted_i = 1'b1; cycles_i = 32'd0; orbit_i = 1'b1;
    tick(); orbit_i = 1'b0;
    #1 chk("R8 zero count quiet", 32'(line_o), 0);
    chk("R8 zero count done", 32'(done_o), 1);
    chk("R8 zero count inactive", 32'(active_o), 0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_bypass();
    t_idle();
    t_free();
    t_counted();
    t_zero();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule